// File: doc/BRIEF.md
# Card Reader Status Byte with Interrupt

This block keeps the 8-bit status byte of a two-slot card reader controller and drives its active-low interrupt line. Some bits show live levels: card presence, the I/O line and the card-active state. Other bits latch events and hold them until the host reads the byte: a presence change, a supervisor fault, an overload or overheat, and the two answer-to-reset timing faults. The host bus engine pulses a read strobe for one clock when a status read completes, and that pulse clears the latched bits.

The interrupt pin goes low while any latched event that needs host attention is pending. After reset it is also held low for as long as the supply supervisor stays active. The presence input is asynchronous, so it passes through a synchronizer before its edges are detected.

Top module: `card_status_reg`

## Requirements
- R1: Bit 0 shows the synchronized presence input (1 = card inserted). It follows `present_i` two clock edges after the input changes.
- R2: Bit 1 sets one edge after a change of the synchronized presence level, whether the card was inserted or removed. A read strobe clears it.
- R3: Bit 2 equals `io_level_i` (1 = line high). Bit 7 equals `active_i` (1 = card active). Both are combinational and are not latched.
- R4: Bit 3 sets on any edge where `sup_active_i` is high and clears on a read strobe. Reset sets it to 1.
- R5: Bit 4 sets on an edge where `ovl_i` is high and clears on a read strobe.
- R6: Bit 5 sets on an edge where `mute_i` is high. Bit 6 sets on an edge where `early_i` is high. A read strobe clears both.
- R7: `irq_n_o` is 0 whenever any of bits 1, 4, 5 or 6 is set. Bit 3 on its own does not pull the interrupt low.
- R8: From reset, `irq_n_o` stays 0 while `sup_active_i` remains high. The hold ends at the first edge where the supervisor is inactive. After that, the supervisor affects the interrupt only through R7.
- R9: An event that arrives on the same edge as a read strobe leaves its bit set.
- R10: During reset, bits 1, 4, 5 and 6 read 0 and bit 3 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| present_i | input | 1 | Card presence level, asynchronous |
| io_level_i | input | 1 | I/O line level |
| sup_active_i | input | 1 | Supply supervisor active / fault |
| ovl_i | input | 1 | Overload or overheat pulse |
| mute_i | input | 1 | No answer to reset in time pulse |
| early_i | input | 1 | Answer to reset too early pulse |
| active_i | input | 1 | Card session active level |
| rd_strobe_i | input | 1 | One-cycle pulse when a status read completes |
| status_o | output | 8 | Status byte |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The assertions check on every cycle that each event input sets its latched bit on the next edge. They also check that a read with no coincident event clears that bit, and that any pending bit among 1, 4, 5 and 6 holds the interrupt low. Some behaviours depend on a sequence of stimulus and are shown only by the bench scenarios: the synchronizer latency of the presence bit, the power-on interrupt hold ending when the supervisor releases, the reset value of the supply-fault bit, and the rule that bit 3 alone leaves the interrupt released.

// File: rtl/card_status_reg.sv
module card_status_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       present_i,
  input  logic       io_level_i,
  input  logic       sup_active_i,
  input  logic       ovl_i,
  input  logic       mute_i,
  input  logic       early_i,
  input  logic       active_i,
  input  logic       rd_strobe_i,
  output logic [7:0] status_o,
  output logic       irq_n_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0]         pres_sync;
  logic                 pres_prev;
  logic [SYNC_STAGES:0] fill;
  logic                 pres_edge;
  logic                 presl, supl, prot, mute, early, por_hold;

  // edge detect only once the synchronizer and its history hold real samples
  assign pres_edge = fill[SYNC_STAGES] & (pres_sync[MSB] ^ pres_prev);

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pres_sync <= '0;
        else        pres_sync <= {pres_sync[MSB-1:0], present_i};
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pres_sync <= '0;
        else        pres_sync <= present_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_prev <= 1'b0;
      fill      <= '0;
      presl     <= 1'b0;
      supl      <= 1'b1;
      prot      <= 1'b0;
      mute      <= 1'b0;
      early     <= 1'b0;
      por_hold  <= 1'b1;
    end else begin
      pres_prev <= pres_sync[MSB];
      fill      <= {fill[SYNC_STAGES-1:0], 1'b1};
      presl     <= pres_edge    | (presl & ~rd_strobe_i);
      supl      <= sup_active_i | (supl  & ~rd_strobe_i);
      prot      <= ovl_i        | (prot  & ~rd_strobe_i);
      mute      <= mute_i       | (mute  & ~rd_strobe_i);
      early     <= early_i      | (early & ~rd_strobe_i);
      por_hold  <= por_hold & sup_active_i;
    end
  end

  assign status_o = {active_i, early, mute, prot, supl, io_level_i, presl, pres_sync[MSB]};
  assign irq_n_o  = ~(presl | prot | mute | early | (por_hold & sup_active_i));
endmodule

// File: rtl/card_status_reg_chk.sv
module card_status_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sup_active_i,
  input logic       ovl_i,
  input logic       mute_i,
  input logic       early_i,
  input logic       rd_strobe_i,
  input logic [7:0] status_o,
  input logic       irq_n_o
);
  a_r4_sup_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sup_active_i |=> status_o[3]);
  a_r5_ovl_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_i |=> status_o[4]);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe_i && !ovl_i) |=> !status_o[4]);
  a_r6_mute_sets: assert property (@(posedge clk) disable iff (!rst_n)
    mute_i |=> status_o[5]);
  a_r6_early_sets: assert property (@(posedge clk) disable iff (!rst_n)
    early_i |=> status_o[6]);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe_i && !mute_i && !early_i) |=> (!status_o[5] && !status_o[6]));
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe_i && ovl_i) |=> status_o[4]);
  a_r7_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[1] || status_o[4] || status_o[5] || status_o[6]) |-> !irq_n_o);
endmodule

bind card_status_reg card_status_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sup_active_i(sup_active_i), .ovl_i(ovl_i),
  .mute_i(mute_i), .early_i(early_i), .rd_strobe_i(rd_strobe_i),
  .status_o(status_o), .irq_n_o(irq_n_o)
);

// File: tb/card_status_reg_test.sv
module card_status_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic present = 1'b0, io_lvl = 1'b0, sup = 1'b1, ovl = 1'b0;
  logic mute = 1'b0, early = 1'b0, active = 1'b0, rd = 1'b0;
  logic [7:0] status;
  logic irq_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  card_status_reg uut (
    .clk(clk), .rst_n(rst_n), .present_i(present), .io_level_i(io_lvl),
    .sup_active_i(sup), .ovl_i(ovl), .mute_i(mute), .early_i(early),
    .active_i(active), .rd_strobe_i(rd), .status_o(status), .irq_n_o(irq_n)
  );

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_read();
    rd = 1'b1; step(); rd = 1'b0;
  endtask

  task automatic t_reset();
    step(2);
    check("R10", {1'b0, status[6], status[5], status[4], status[3], status[1]}, 9'h002);
    check("R8 hold", {8'h0, irq_n}, 9'h000);
    rst_n = 1'b1; step(3);
    check("R8 hold while sup", {8'h0, irq_n}, 9'h000);
    check("R4 sup sets", {8'h0, status[3]}, 9'h001);
    sup = 1'b0; step();
    check("R8 release", {8'h0, irq_n}, 9'h001);
    host_read();
    check("R4 read clears", {8'h0, status[3]}, 9'h000);
    sup = 1'b1; step(); sup = 1'b0; step();
    check("R4 pulse", {8'h0, status[3]}, 9'h001);
    check("R7 bit3 alone no irq", {8'h0, irq_n}, 9'h001);
    host_read();
  endtask

  task automatic t_presence();
    present = 1'b1; step();
    check("R1 not yet", {8'h0, status[0]}, 9'h000);
    step();
    check("R1 latency", {8'h0, status[0]}, 9'h001);
    check("R2 not yet", {8'h0, status[1]}, 9'h000);
    step();
    check("R2 insert", {8'h0, status[1]}, 9'h001);
    check("R7 presl irq", {8'h0, irq_n}, 9'h000);
    host_read();
    check("R2 read clears", {7'h0, status[1], irq_n}, 9'h001);
    present = 1'b0; step(3);
    check("R2 extract", {7'h0, status[1], status[0]}, 9'h002);
    host_read();
  endtask

  task automatic t_live();
    io_lvl = 1'b1; active = 1'b1; #1;
    check("R3 high", {7'h0, status[7], status[2]}, 9'h003);
    io_lvl = 1'b0; #1;
    check("R3 io low", {7'h0, status[7], status[2]}, 9'h002);
    active = 1'b0; #1;
    check("R3 inactive", {7'h0, status[7], status[2]}, 9'h000);
    step();
  endtask

  task automatic t_overload();
    ovl = 1'b1; step(); ovl = 1'b0; step(2);
    check("R5 sets", {7'h0, status[4], irq_n}, 9'h002);
    host_read();
    check("R5 clears", {7'h0, status[4], irq_n}, 9'h001);
  endtask

  task automatic t_atr();
    mute = 1'b1; step(); mute = 1'b0;
    check("R6 mute", {6'h0, status[6], status[5], irq_n}, 9'h002);
    host_read();
    early = 1'b1; step(); early = 1'b0;
    check("R6 early", {6'h0, status[6], status[5], irq_n}, 9'h004);
    host_read();
    check("R6 clears", {6'h0, status[6], status[5], irq_n}, 9'h001);
  endtask

  task automatic t_collide();
    rd = 1'b1; ovl = 1'b1; mute = 1'b1; step();
    rd = 1'b0; ovl = 1'b0; mute = 1'b0;
    check("R9 kept", {6'h0, status[5], status[4], irq_n}, 9'h006);
    host_read();
    check("R9 later read", {6'h0, status[5], status[4], irq_n}, 9'h001);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_presence(); t_live(); t_overload(); t_atr(); t_collide();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: got timeout expected completion");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule